// File: doc/BRIEF.md
# Multicore Private Window Decoder

This block sits at the entry of a 4 KB private peripheral window that up to four cores share. Each access arrives with an address and the number of the core that issued it. The block sends the access to one of three places. The first is a small local bank of snoop-control registers, which this block holds itself. The second is the interrupt-controller CPU interface of one core. The third is one of the per-core timer instances, each core owning one timer and one watchdog.

Every per-core target can be reached in two ways. A low "own-core" window always lands on the instance that belongs to the requesting core. Higher banked windows name the core explicitly through the address. Address bit 5 picks the timer or the watchdog inside a core's timer pair. Forwarded accesses leave the block with a target code, an instance index and a trimmed local register offset. Snoop-control accesses and illegal offsets are answered directly with a response pulse.

The block also routes each timer instance's event line onto the matching private interrupt line of its core.

Top module: `mpriv_decoder`

## Requirements
- R1: Only address bits [11:0] are decoded; the upper address bits have no effect on any output.
- R2: Offsets 0x000–0x0FF reach the local snoop-control bank: control at 0x00, configuration at 0x04, CPU status at 0x08, invalidate-all at 0x0C. These accesses are answered with rsp_valid one cycle after the request, and rsp_rdata carries the register value from before the access. No forward is made.
- R3: A write to control stores only wdata bit 0. Control reads back as that bit in bit 0, with all other bits zero.
- R4: Configuration reads CFG_VALUE (default 0xF3). CPU status and invalidate-all read 0. Writes to these three are ignored without error.
- R5: Offsets 0x100–0x1FF forward with fwd_tgt=2 (interrupt interface), fwd_idx = req_core and fwd_off = addr[7:0].
- R6: Offsets 0x200–0x5FF forward with fwd_tgt=2, fwd_idx = addr[11:8]−2 and fwd_off = addr[7:0].
- R7: Offsets 0x600–0x6FF forward with fwd_tgt=3 (timer), fwd_idx = 2·req_core + addr[5] (1 = watchdog) and fwd_off = addr[3:0] zero-extended.
- R8: Offsets 0x700–0xAFF forward with fwd_tgt=3, fwd_idx = 2·(addr[11:8]−7) + addr[5] and fwd_off = addr[3:0] zero-extended.
- R9: A snoop-control offset other than the four listed, or any offset ≥ 0xB00, raises rsp_valid and rsp_err together for one cycle. In that cycle rsp_rdata is 0, nothing is forwarded, and control is left unchanged.
- R10: A forward appears as a one-cycle fwd_valid pulse one cycle after the request and carries req_write and req_wdata. fwd_valid and rsp_valid are never high together.
- R11: Timer event i drives ppi_out bit (i/2)·32 + 29 + (i mod 2) in the same cycle. All other ppi_out bits are 0.
- R12: After reset fwd_valid, rsp_valid and rsp_err are low and control reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | 2 | Number of the requesting core |
| req_addr | input | 32 | Access address (low 12 bits decoded) |
| req_wdata | input | 32 | Write data |
| fwd_valid | output | 1 | Forwarded access strobe |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_tgt | output | 2 | Target code: 2 interrupt interface, 3 timer |
| fwd_idx | output | 3 | Core index or timer instance index |
| fwd_off | output | 8 | Local register offset |
| fwd_wdata | output | 32 | Forwarded write data |
| rsp_valid | output | 1 | Local response strobe (snoop-control or error) |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Local read data |
| tmr_evt | input | 8 | Event lines of the eight timer instances |
| ppi_out | output | 128 | Private interrupt lines, 32 per core |

## Verification
Every decode result and every local response is registered once, so it is due on the edge right after the edge that samples req_valid. The bench drives a request on a falling edge and compares all outputs on the next falling edge. It then drops req_valid, so each comparison belongs to exactly one request. The interrupt routing has no register, and its output is compared a short delay after tmr_evt changes, with no clock edge in between. The bench keeps a model of the control bit that tracks only legal writes. Later control reads therefore show whether ignored or erroneous writes disturbed it.

// File: rtl/mpriv_pkg.sv
package mpriv_pkg;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_SCU  = 2'd1,
      TGT_GIC  = 2'd2,
      TGT_TMR  = 2'd3
   } tgt_e;

   typedef enum logic [1:0] {
      SCU_CTRL  = 2'd0,
      SCU_CFG   = 2'd1,
      SCU_STAT  = 2'd2,
      SCU_INVAL = 2'd3
   } scu_reg_e;

   localparam int unsigned WIN_BITS     = 12;
   localparam int unsigned PAGE_BITS    = 4;
   localparam int unsigned LOC_OFF_W    = 8;
   localparam int unsigned TMR_OFF_W    = 4;
   localparam int unsigned TMR_SEL_BIT  = 5;
   localparam int unsigned LINES_PER_CORE = 32;
   localparam int unsigned TMR_LINE_BASE  = 29;

   localparam logic [3:0] PG_SCU      = 4'h0;
   localparam logic [3:0] PG_GIC_OWN  = 4'h1;
   localparam logic [3:0] PG_GIC_BASE = 4'h2;
   localparam logic [3:0] PG_TMR_OWN  = 4'h6;
   localparam logic [3:0] PG_TMR_BASE = 4'h7;

endpackage

// File: rtl/mpriv_addr_map.sv
module mpriv_addr_map
   import mpriv_pkg::*;
#(
   parameter int unsigned NCORE  = 4,
   parameter int unsigned CORE_W = 2,
   parameter int unsigned IDX_W  = 3
) (
   input  logic [WIN_BITS-1:0]  off_i,
   input  logic [CORE_W-1:0]    core_i,
   output tgt_e                 tgt_o,
   output logic [IDX_W-1:0]     idx_o,
   output logic [LOC_OFF_W-1:0] loc_off_o,
   output scu_reg_e             scu_reg_o,
   output logic                 err_o
);

   localparam int unsigned BANK_W = PAGE_BITS;

   logic [PAGE_BITS-1:0] page;
   logic [BANK_W-1:0]    bank_core;
   logic [BANK_W:0]      tmr_idx;
   logic [BANK_W-1:0]    own_core;
   tgt_e                 raw_tgt;

   assign page     = off_i[WIN_BITS-1 -: PAGE_BITS];
   assign own_core = {{(BANK_W-CORE_W){1'b0}}, core_i};
   assign tmr_idx  = {bank_core, off_i[TMR_SEL_BIT]};

   always_comb begin
      raw_tgt   = TGT_NONE;
      bank_core = '0;
      scu_reg_o = SCU_CTRL;
      err_o     = 1'b0;
      unique case (page)
         PG_SCU: begin
            raw_tgt = TGT_SCU;
            unique case (off_i[LOC_OFF_W-1:0])
               8'h00:   scu_reg_o = SCU_CTRL;
               8'h04:   scu_reg_o = SCU_CFG;
               8'h08:   scu_reg_o = SCU_STAT;
               8'h0C:   scu_reg_o = SCU_INVAL;
               default: begin
                  raw_tgt = TGT_NONE;
                  err_o   = 1'b1;
               end
            endcase
         end
         PG_GIC_OWN: begin
            raw_tgt   = TGT_GIC;
            bank_core = own_core;
         end
         4'h2, 4'h3, 4'h4, 4'h5: begin
            raw_tgt   = TGT_GIC;
            bank_core = page - PG_GIC_BASE;
         end
         PG_TMR_OWN: begin
            raw_tgt   = TGT_TMR;
            bank_core = own_core;
         end
         4'h7, 4'h8, 4'h9, 4'hA: begin
            raw_tgt   = TGT_TMR;
            bank_core = page - PG_TMR_BASE;
         end
         default: begin
            raw_tgt = TGT_NONE;
            err_o   = 1'b1;
         end
      endcase
      if ((raw_tgt == TGT_GIC || raw_tgt == TGT_TMR) && (int'(bank_core) >= NCORE)) begin
         raw_tgt = TGT_NONE;
         err_o   = 1'b1;
      end
   end

   always_comb begin
      tgt_o     = raw_tgt;
      idx_o     = '0;
      loc_off_o = off_i[LOC_OFF_W-1:0];
      if (raw_tgt == TGT_GIC) begin
         idx_o = bank_core[IDX_W-1:0];
      end else if (raw_tgt == TGT_TMR) begin
         idx_o     = tmr_idx[IDX_W-1:0];
         loc_off_o = {{(LOC_OFF_W-TMR_OFF_W){1'b0}}, off_i[TMR_OFF_W-1:0]};
      end
   end

endmodule

// File: rtl/mpriv_scu_regs.sv
module mpriv_scu_regs
   import mpriv_pkg::*;
#(
   parameter int unsigned         DATA_W    = 32,
   parameter logic [DATA_W-1:0]   CFG_VALUE = 'hF3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  scu_reg_e          acc_reg,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] rd_data
);

   logic ctrl_q;
   logic ctrl_we;
   logic unused_wdata;

   assign ctrl_we      = acc_en && acc_wr && (acc_reg == SCU_CTRL);
   assign unused_wdata = ^acc_wdata[DATA_W-1:1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= 1'b0;
      end else if (ctrl_we) begin
         ctrl_q <= acc_wdata[0];
      end
   end

   always_comb begin
      unique case (acc_reg)
         SCU_CTRL: rd_data = {{(DATA_W-1){1'b0}}, ctrl_q};
         SCU_CFG:  rd_data = CFG_VALUE;
         default:  rd_data = '0;
      endcase
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_we |=> $stable(ctrl_q)); // R4

   AST_CTRL_TAKES_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> (ctrl_q == $past(acc_wdata[0]))); // R3

endmodule

// File: rtl/mpriv_ppi_route.sv
module mpriv_ppi_route
   import mpriv_pkg::*;
#(
   parameter int unsigned NCORE = 4
) (
   input  logic [2*NCORE-1:0]              evt_i,
   output logic [NCORE*LINES_PER_CORE-1:0] ppi_o
);

   for (genvar c = 0; c < NCORE; c++) begin : g_core
      localparam int unsigned BASE = c * LINES_PER_CORE;
      assign ppi_o[BASE +: TMR_LINE_BASE]      = '0;
      assign ppi_o[BASE + TMR_LINE_BASE]       = evt_i[2*c];
      assign ppi_o[BASE + TMR_LINE_BASE + 1]   = evt_i[2*c+1];
      assign ppi_o[BASE + LINES_PER_CORE - 1]  = 1'b0;
   end

endmodule

// File: rtl/mpriv_decoder.sv
module mpriv_decoder
   import mpriv_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       NCORE     = 4,
   parameter logic [DATA_W-1:0] CFG_VALUE = 'hF3,
   localparam int unsigned      CORE_W    = (NCORE > 1) ? $clog2(NCORE) : 1,
   localparam int unsigned      IDX_W     = $clog2(2*NCORE),
   localparam int unsigned      NTMR      = 2*NCORE,
   localparam int unsigned      PPI_W     = NCORE*LINES_PER_CORE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [CORE_W-1:0]    req_core,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 fwd_valid,
   output logic                 fwd_write,
   output logic [1:0]           fwd_tgt,
   output logic [IDX_W-1:0]     fwd_idx,
   output logic [LOC_OFF_W-1:0] fwd_off,
   output logic [DATA_W-1:0]    fwd_wdata,
   output logic                 rsp_valid,
   output logic                 rsp_err,
   output logic [DATA_W-1:0]    rsp_rdata,
   input  logic [NTMR-1:0]      tmr_evt,
   output logic [PPI_W-1:0]     ppi_out
);

   if (NCORE < 1 || NCORE > 4) begin : g_bad_ncore
      $error("mpriv_decoder: NCORE must be 1..4");
   end
   if (ADDR_W < WIN_BITS) begin : g_bad_addr
      $error("mpriv_decoder: ADDR_W below window size");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("mpriv_decoder: DATA_W must cover the configuration value");
   end

   if (ADDR_W > WIN_BITS) begin : g_hi_addr
      logic unused_hi_addr;
      assign unused_hi_addr = ^req_addr[ADDR_W-1:WIN_BITS];
   end

   tgt_e                 dec_tgt;
   logic [IDX_W-1:0]     dec_idx;
   logic [LOC_OFF_W-1:0] dec_off;
   scu_reg_e             dec_scu_reg;
   logic                 dec_err;
   logic [DATA_W-1:0]    scu_rdata;
   logic                 scu_acc;
   logic                 fwd_go;

   mpriv_addr_map #(
      .NCORE  (NCORE),
      .CORE_W (CORE_W),
      .IDX_W  (IDX_W)
   ) u_map (
      .off_i     (req_addr[WIN_BITS-1:0]),
      .core_i    (req_core),
      .tgt_o     (dec_tgt),
      .idx_o     (dec_idx),
      .loc_off_o (dec_off),
      .scu_reg_o (dec_scu_reg),
      .err_o     (dec_err)
   );

   assign scu_acc = req_valid && (dec_tgt == TGT_SCU);
   assign fwd_go  = req_valid && (dec_tgt == TGT_GIC || dec_tgt == TGT_TMR);

   mpriv_scu_regs #(
      .DATA_W    (DATA_W),
      .CFG_VALUE (CFG_VALUE)
   ) u_scu (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_en    (scu_acc),
      .acc_wr    (req_write),
      .acc_reg   (dec_scu_reg),
      .acc_wdata (req_wdata),
      .rd_data   (scu_rdata)
   );

   mpriv_ppi_route #(
      .NCORE (NCORE)
   ) u_ppi (
      .evt_i (tmr_evt),
      .ppi_o (ppi_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid <= 1'b0;
         fwd_write <= 1'b0;
         fwd_tgt   <= TGT_NONE;
         fwd_idx   <= '0;
         fwd_off   <= '0;
         fwd_wdata <= '0;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         fwd_valid <= fwd_go;
         if (fwd_go) begin
            fwd_write <= req_write;
            fwd_tgt   <= dec_tgt;
            fwd_idx   <= dec_idx;
            fwd_off   <= dec_off;
            fwd_wdata <= req_wdata;
         end
         rsp_valid <= scu_acc || (req_valid && dec_err);
         rsp_err   <= req_valid && dec_err;
         rsp_rdata <= scu_acc ? scu_rdata : '0;
      end
   end

   AST_EXCL_PATHS: assert property (@(posedge clk) disable iff (!rst_n)
      !(fwd_valid && rsp_valid)); // R10

   AST_FWD_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> $past(req_valid)); // R10

   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R9

   AST_CFG_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[WIN_BITS-1:0] == 12'h004) |=>
         (rsp_valid && !rsp_err && rsp_rdata == CFG_VALUE)); // R4

   AST_HIGH_OFF_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[WIN_BITS-1:0] >= 12'hB00) |=> (rsp_err && !fwd_valid)); // R9

endmodule

// File: tb/mpriv_decoder_tb.sv
`timescale 1ns/1ps
module mpriv_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_core = '0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        fwd_valid, fwd_write;
   logic [1:0]  fwd_tgt;
   logic [2:0]  fwd_idx;
   logic [7:0]  fwd_off;
   logic [31:0] fwd_wdata;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic [7:0]  tmr_evt = '0;
   logic [127:0] ppi_out;

   int n_tests = 0;
   int n_fail  = 0;
   logic model_ctrl = 1'b0;

   always #2.5 clk = ~clk;

   mpriv_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
      .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_tgt(fwd_tgt),
      .fwd_idx(fwd_idx), .fwd_off(fwd_off), .fwd_wdata(fwd_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .tmr_evt(tmr_evt), .ppi_out(ppi_out)
   );

   task automatic report(input logic ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Reference decode built from the requirement list.
   task automatic expect_access(input logic wr, input logic [31:0] a, input logic [1:0] core,
                                input logic [31:0] wd,
                                output logic e_fwd, output logic e_rsp, output logic e_err,
                                output logic [1:0] e_tgt, output logic [2:0] e_idx,
                                output logic [7:0] e_off, output logic [31:0] e_rd,
                                output string tag);
      logic [11:0] off;
      logic [3:0]  pg;
      off = a[11:0];
      pg  = off[11:8];
      e_fwd = 0; e_rsp = 0; e_err = 0; e_tgt = 0; e_idx = 0; e_off = 0; e_rd = 0;
      tag = "R9";
      if (pg == 4'h0) begin
         case (off[7:0])
            8'h00: begin
               e_rsp = 1; e_rd = {31'b0, model_ctrl}; tag = "R3";
               if (wr) model_ctrl = wd[0];
            end
            8'h04: begin e_rsp = 1; e_rd = 32'hF3; tag = "R4"; end
            8'h08, 8'h0C: begin e_rsp = 1; e_rd = 0; tag = "R4"; end
            default: begin e_rsp = 1; e_err = 1; tag = "R9"; end
         endcase
      end else if (pg == 4'h1) begin
         e_fwd = 1; e_tgt = 2; e_idx = {1'b0, core}; e_off = off[7:0]; tag = "R5";
      end else if (pg >= 4'h2 && pg <= 4'h5) begin
         e_fwd = 1; e_tgt = 2; e_idx = 3'(pg - 4'h2); e_off = off[7:0]; tag = "R6";
      end else if (pg == 4'h6) begin
         e_fwd = 1; e_tgt = 3; e_idx = {core, off[5]}; e_off = {4'b0, off[3:0]}; tag = "R7";
      end else if (pg >= 4'h7 && pg <= 4'hA) begin
         logic [3:0] b;
         b = pg - 4'h7;
         e_fwd = 1; e_tgt = 3; e_idx = {b[1:0], off[5]}; e_off = {4'b0, off[3:0]}; tag = "R8";
      end else begin
         e_rsp = 1; e_err = 1; tag = "R9";
      end
   endtask

   task automatic access(input logic wr, input logic [31:0] a, input logic [1:0] core,
                         input logic [31:0] wd, input string force_tag);
      logic e_fwd, e_rsp, e_err;
      logic [1:0] e_tgt;
      logic [2:0] e_idx;
      logic [7:0] e_off;
      logic [31:0] e_rd;
      string tag;
      logic ok;
      expect_access(wr, a, core, wd, e_fwd, e_rsp, e_err, e_tgt, e_idx, e_off, e_rd, tag);
      if (force_tag != "") tag = force_tag;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_core = core; req_wdata = wd;
      @(negedge clk);
      req_valid = 0;
      ok = (fwd_valid == e_fwd) && (rsp_valid == e_rsp) && (rsp_err == e_err);
      if (e_rsp) ok = ok && (rsp_rdata == e_rd);
      if (e_fwd) ok = ok && (fwd_tgt == e_tgt) && (fwd_idx == e_idx) && (fwd_off == e_off)
                         && (fwd_write == wr) && (fwd_wdata == wd);
      report(ok, tag, $sformatf("addr %08h core %0d", a, core),
             {fwd_valid, rsp_valid, rsp_err, fwd_tgt, fwd_idx, fwd_off, rsp_rdata},
             {e_fwd, e_rsp, e_err, e_tgt, e_idx, e_off, e_rd});
   endtask

   function automatic logic [127:0] exp_ppi(input logic [7:0] ev);
      logic [127:0] v;
      v = '0;
      for (int i = 0; i < 8; i++) v[(i/2)*32 + 29 + (i%2)] = ev[i];
      return v;
   endfunction

   initial begin
      #(200000 * 5);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R12: reset state
      report(!fwd_valid && !rsp_valid && !rsp_err, "R12", "valids after reset",
             {fwd_valid, rsp_valid, rsp_err}, 0);
      access(0, 32'h0000_0000, 0, 0, "R12");

      // R3: only bit 0 of control is kept
      access(1, 32'h0000_0000, 1, 32'hFFFF_FFFE, "R3");
      access(0, 32'h0000_0000, 1, 0, "R3");
      access(1, 32'h0000_0000, 2, 32'h0000_0003, "R3");
      access(0, 32'h0000_0000, 2, 0, "R3");

      // R4: read-only registers, writes ignored
      access(1, 32'h0000_0004, 0, 32'h0, "R4");
      access(0, 32'h0000_0004, 0, 0, "R4");
      access(1, 32'h0000_0008, 0, 32'hFFFF_FFFF, "R4");
      access(0, 32'h0000_0008, 0, 0, "R4");
      access(1, 32'h0000_000C, 3, 32'hFFFF_FFFF, "R4");
      access(0, 32'h0000_000C, 3, 0, "R4");
      access(0, 32'h0000_0000, 3, 0, "R4");

      // R9: illegal offsets, control must survive an erroneous write
      access(1, 32'h0000_0010, 0, 32'h0, "R9");
      access(1, 32'h0000_0002, 0, 32'h0, "R9");
      access(0, 32'h0000_0B00, 0, 0, "R9");
      access(1, 32'h0000_0FFF, 0, 0, "R9");
      access(0, 32'h0000_0000, 0, 0, "R9");

      // R1: upper address bits ignored
      access(0, 32'hABCD_E004, 2, 0, "R1");
      access(0, 32'h5555_5624, 1, 0, "R1");

      // R2 local bank answered without a forward
      access(0, 32'h0000_0008, 1, 0, "R2");

      // R5..R8 window corners
      access(0, 32'h0000_01A4, 3, 0, "R5");
      access(1, 32'h0000_01FF, 0, 32'h1234_5678, "R5");
      access(0, 32'h0000_02FC, 3, 0, "R6");
      access(1, 32'h0000_05F0, 0, 32'hCAFE_0001, "R6");
      access(0, 32'h0000_0620, 1, 0, "R7");
      access(1, 32'h0000_060C, 2, 32'h0000_00AA, "R7");
      access(0, 32'h0000_070C, 3, 0, "R8");
      access(1, 32'h0000_0A2C, 0, 32'hDEAD_BEEF, "R8");

      // R10: back-to-back forward then local response
      access(1, 32'h0000_0824, 2, 32'h0F0F_0F0F, "R10");
      access(0, 32'h0000_0004, 2, 0, "R10");

      // Random mix across the window
      for (int k = 0; k < 400; k++) begin
         logic [31:0] a;
         logic [11:0] o;
         if (k % 3 == 0) o = {8'h00, 2'b00, 2'($urandom_range(0, 3)), 2'b00} | ($urandom_range(0, 7) == 0 ? 12'h030 : 12'h0);
         else o = 12'($urandom_range(0, 12'hFFF));
         a = {20'($urandom), o};
         access(1'($urandom), a, 2'($urandom), $urandom, "");
      end

      // R11: interrupt routing (combinational)
      for (int k = 0; k < 24; k++) begin
         logic [7:0] ev;
         ev = (k < 8) ? 8'(1 << k) : 8'($urandom);
         tmr_evt = ev;
         #1;
         report(ppi_out == exp_ppi(ev), "R11", $sformatf("ppi for evt %02h", ev),
                ppi_out, exp_ppi(ev));
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule